// File: doc/BRIEF.md
# Escape-prefix opcode modifier

This decode-stage block sits behind the opcode fetch and watches a stream of opcode bytes, each qualified by a valid strobe. The byte 0xFB is an escape. It is swallowed and never issued. Instead it arms a pending flag that changes how the next real opcode is classified.

For every real opcode the block issues one registered record. The record holds the opcode, a flag saying whether a prefix preceded it, and a resolved addressing-mode code. It also carries two override strobes: one swaps the index register and one selects the user stack pointer. The execute stage uses the mode code and the overrides. Executing the instructions is not part of this block.

The prefix adds one level of indirection to the absolute subroutine call and to the zero-page bit reset/set group. For the stack-relative group, the prefix picks the user stack pointer, but only in kernel mode. For the indexed ALU group, it swaps the index register. Any other opcode keeps its normal decode. An interrupt acknowledge or a reset drops a pending prefix.

Top module: `pfx_decoder`

## Requirements
- R1: A valid byte equal to 0xFB is never issued. The cycle after it shows issue_valid_o low, and it arms the pending prefix.
- R2: A valid non-prefix byte on clock edge N is issued in the cycle after edge N: issue_valid_o is 1 and issue_op_o equals the byte. In any cycle with no issue, every output is 0.
- R3: Opcode 0x20 resolves to mode 1 (absolute) without a prefix and to mode 2 (absolute indirect) with one.
- R4: Opcodes with low nibble 0x7 (the bit reset/set group) resolve to mode 3 (zero page) without a prefix and to mode 4 (zero-page indirect) with one.
- R5: A prefix affects only the next issued opcode. After that issue the pending flag is clear, even when idle cycles come between the prefix and the opcode.
- R6: Two or more prefix bytes in a row act as one. The next opcode is issued with prefixed_o equal to 1.
- R7: Opcodes with low nibble 0x3 resolve to mode 5 when the high nibble is even and to mode 6 when it is odd. usp_sel_o is 1 only when a prefix is present and kernel_i was 1 when the opcode was accepted.
- R8: Opcodes with an odd high nibble and low nibble 0x1, 0x5, 0x9 or 0xD resolve to mode 7. idx_swap_o equals prefixed_o for them.
- R9: Every other opcode resolves to mode 0 with both overrides at 0, whether or not it is prefixed. prefixed_o still reports the prefix.
- R10: int_ack_i clears a pending prefix. An opcode accepted in the same cycle as int_ack_i is issued unprefixed, and a prefix byte in that cycle leaves nothing pending.
- R11: While rst_ni is low, all outputs are 0 and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | op_byte_i holds a fetched byte |
| op_byte_i | input | 8 | Fetched opcode byte |
| int_ack_i | input | 1 | Interrupt acknowledge; drops a pending prefix |
| kernel_i | input | 1 | Processor is in kernel mode |
| issue_valid_o | output | 1 | An opcode record is issued this cycle |
| issue_op_o | output | 8 | Issued opcode |
| prefixed_o | output | 1 | The issued opcode followed a prefix |
| amode_o | output | 3 | Resolved addressing-mode code |
| idx_swap_o | output | 1 | Swap the index register |
| usp_sel_o | output | 1 | Use the user stack pointer |

## Verification
The hardest case to reach from the ports is a prefix that stays armed across idle cycles and then meets an interrupt acknowledge, a second prefix, or a change in kernel mode before its opcode arrives. Directed sequences build each of these cases: repeated prefixes, prefixes followed by gaps, an acknowledge in the same cycle as the opcode, and an acknowledge in the same cycle as the prefix byte. A long random run follows that emits the prefix byte often and biases opcodes toward the remapped groups. A behavioural model in the bench predicts every output on every clock.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] PFX_CODE = 8'hFB;
  localparam logic [OP_W-1:0] JSR_ABS  = 8'h20;

  typedef enum logic [2:0] {
    AM_NONE    = 3'd0,
    AM_ABS     = 3'd1,
    AM_ABS_IND = 3'd2,
    AM_ZP      = 3'd3,
    AM_ZP_IND  = 3'd4,
    AM_STK     = 3'd5,
    AM_STK_IY  = 3'd6,
    AM_IDX     = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    CL_PLAIN,
    CL_CALL,
    CL_BITZP,
    CL_STK,
    CL_IDX
  } op_class_e;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_class_e       cls_o,
  output logic            is_pfx_o
);
  localparam int unsigned NIB = OP_W / 2;

  logic [NIB-1:0] lo_nib, hi_nib;
  assign lo_nib = op_i[NIB-1:0];
  assign hi_nib = op_i[OP_W-1:NIB];

  assign is_pfx_o = (op_i == PFX_CODE);

  always_comb begin
    cls_o = CL_PLAIN;
    if (op_i == JSR_ABS)                         cls_o = CL_CALL;
    else if (lo_nib == NIB'(4'h7))               cls_o = CL_BITZP;
    else if (lo_nib == NIB'(4'h3))               cls_o = CL_STK;
    else if (hi_nib[0] && (lo_nib[1:0] == 2'b01)) cls_o = CL_IDX;
  end
endmodule

// File: rtl/pfx_state.sv
module pfx_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_valid_i,
  input  logic is_pfx_i,
  input  logic int_ack_i,
  output logic pending_o
);
  logic pending_d;

  always_comb begin
    pending_d = pending_o;
    if (int_ack_i)       pending_d = 1'b0;
    else if (op_valid_i) pending_d = is_pfx_i; // repeated prefixes stay set
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_o <= 1'b0;
    else         pending_o <= pending_d;
  end
endmodule

// File: rtl/pfx_remap.sv
module pfx_remap
  import pfx_pkg::*;
(
  input  op_class_e       cls_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            pfx_i,
  input  logic            kernel_i,
  output amode_e          amode_o,
  output logic            idx_swap_o,
  output logic            usp_sel_o
);
  always_comb begin
    amode_o    = AM_NONE;
    idx_swap_o = 1'b0;
    usp_sel_o  = 1'b0;
    unique case (cls_i)
      CL_CALL:  amode_o = pfx_i ? AM_ABS_IND : AM_ABS;
      CL_BITZP: amode_o = pfx_i ? AM_ZP_IND  : AM_ZP;
      CL_STK: begin
        amode_o   = op_i[OP_W/2] ? AM_STK_IY : AM_STK;
        usp_sel_o = pfx_i && kernel_i;
      end
      CL_IDX: begin
        amode_o    = AM_IDX;
        idx_swap_o = pfx_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder
  import pfx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_byte_i,
  input  logic            int_ack_i,
  input  logic            kernel_i,
  output logic            issue_valid_o,
  output logic [OP_W-1:0] issue_op_o,
  output logic            prefixed_o,
  output logic [2:0]      amode_o,
  output logic            idx_swap_o,
  output logic            usp_sel_o
);
  op_class_e cls;
  logic      is_pfx, pending, eff_pfx, issue_d;
  amode_e    amode_d;
  logic      idx_d, usp_d;

  pfx_classify u_cls (.op_i(op_byte_i), .cls_o(cls), .is_pfx_o(is_pfx));

  pfx_state u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i),
    .is_pfx_i(is_pfx), .int_ack_i(int_ack_i), .pending_o(pending)
  );

  assign eff_pfx = pending && !int_ack_i;
  assign issue_d = op_valid_i && !is_pfx;

  pfx_remap u_remap (
    .cls_i(cls), .op_i(op_byte_i), .pfx_i(eff_pfx), .kernel_i(kernel_i),
    .amode_o(amode_d), .idx_swap_o(idx_d), .usp_sel_o(usp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o <= 1'b0;
      issue_op_o    <= '0;
      prefixed_o    <= 1'b0;
      amode_o       <= AM_NONE;
      idx_swap_o    <= 1'b0;
      usp_sel_o     <= 1'b0;
    end else begin
      issue_valid_o <= issue_d;
      issue_op_o    <= issue_d ? op_byte_i : '0;
      prefixed_o    <= issue_d && eff_pfx;
      amode_o       <= issue_d ? amode_d : AM_NONE;
      idx_swap_o    <= issue_d && idx_d;
      usp_sel_o     <= issue_d && usp_d;
    end
  end

  assert_pfx_not_issued_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_byte_i == PFX_CODE) |=> !issue_valid_o);

  assert_one_shot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && prefixed_o) |=> !prefixed_o);

  assert_usp_kernel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !kernel_i) |=> !usp_sel_o);

  assert_ack_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_i |=> !prefixed_o);

  assert_indirect_needs_pfx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amode_o == AM_ABS_IND || amode_o == AM_ZP_IND) |-> prefixed_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (!issue_valid_o && !prefixed_o && !usp_sel_o && !idx_swap_o));
endmodule

// File: tb/pfx_decoder_test.sv
module pfx_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0, ack = 1'b0, kern = 1'b0;
  logic [7:0] b = 8'h00;
  logic       o_v, o_p, o_x, o_u;
  logic [7:0] o_op;
  logic [2:0] o_am;

  int tests = 0, fails = 0;
  bit pend = 0;
  bit e_v = 0, e_p = 0, e_x = 0, e_u = 0;
  logic [7:0] e_op = 0;
  logic [2:0] e_am = 0;
  string e_req = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(v), .op_byte_i(b),
    .int_ack_i(ack), .kernel_i(kern), .issue_valid_o(o_v), .issue_op_o(o_op),
    .prefixed_o(o_p), .amode_o(o_am), .idx_swap_o(o_x), .usp_sel_o(o_u)
  );

  // Predict the record issued at the next edge from the inputs just chosen.
  task automatic predict();
    bit p;
    p = pend && !ack;
    {e_v, e_p, e_x, e_u, e_op, e_am} = '0;
    e_req = "R2";
    if (v && b == 8'hFB) e_req = "R1";
    else if (v) begin
      e_v = 1; e_op = b; e_p = p;
      if (b == 8'h20) begin e_am = p ? 2 : 1; e_req = "R3"; end
      else if (b[3:0] == 4'h7) begin e_am = p ? 4 : 3; e_req = "R4"; end
      else if (b[3:0] == 4'h3) begin
        e_am = b[4] ? 6 : 5; e_u = p && kern; e_req = "R7";
      end else if (b[4] && (b[3:0] == 4'h1 || b[3:0] == 4'h5 ||
                            b[3:0] == 4'h9 || b[3:0] == 4'hD)) begin
        e_am = 7; e_x = p; e_req = "R8";
      end else e_req = "R9";
      if (ack) e_req = "R10";
    end
    if (ack) pend = 0;
    else if (v) pend = (b == 8'hFB);
  endtask

  task automatic compare();
    tests++;
    if (o_v !== e_v || o_op !== e_op || o_p !== e_p || o_am !== e_am ||
        o_x !== e_x || o_u !== e_u) begin
      fails++;
      $display("FAIL %s: got v=%0b op=%h p=%0b am=%0d x=%0b u=%0b exp v=%0b op=%h p=%0b am=%0d x=%0b u=%0b",
               e_req, o_v, o_op, o_p, o_am, o_x, o_u, e_v, e_op, e_p, e_am, e_x, e_u);
    end
  endtask

  task automatic step(input bit vv, input logic [7:0] bb, input bit aa, input bit kk);
    @(negedge clk);
    compare();
    v = vv; b = bb; ack = aa; kern = kk;
    predict();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    step(0, 8'h00, 0, 0);
    // R3: call plain and prefixed
    step(1, 8'h20, 0, 0);
    step(1, 8'hFB, 0, 0);   // R1
    step(1, 8'h20, 0, 0);
    // R4: bit group plain / prefixed across idle gap (R5)
    step(1, 8'h87, 0, 0);
    step(1, 8'hFB, 0, 0);
    step(0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 0);
    step(1, 8'h77, 0, 0);
    step(1, 8'h77, 0, 0);   // R5: no longer prefixed
    // R6: repeated prefixes
    step(1, 8'hFB, 0, 0);
    step(1, 8'hFB, 0, 0);
    step(1, 8'hFB, 0, 0);
    step(1, 8'hF7, 0, 0);
    // R7: stack group, kernel vs user
    step(1, 8'hFB, 0, 1);
    step(1, 8'hA3, 0, 1);
    step(1, 8'hFB, 0, 1);
    step(1, 8'hB3, 0, 0);
    step(1, 8'h13, 0, 1);
    // R8: index swap
    step(1, 8'hFB, 0, 0);
    step(1, 8'hB9, 0, 0);
    step(1, 8'h7D, 0, 0);
    // R9: prefix ignored by plain opcode
    step(1, 8'hFB, 0, 1);
    step(1, 8'hEA, 0, 1);
    step(1, 8'h20, 0, 0);
    // R10: ack with opcode, ack with prefix byte, ack during gap
    step(1, 8'hFB, 0, 0);
    step(1, 8'h20, 1, 0);
    step(1, 8'hFB, 1, 0);
    step(1, 8'h07, 0, 0);
    step(1, 8'hFB, 0, 0);
    step(0, 8'h00, 1, 0);
    step(1, 8'h20, 0, 0);
    // random run over all cases
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] rb;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: rb = 8'hFB;
        3:       rb = 8'h20;
        4:       rb = {4'($urandom), 4'h7};
        5:       rb = {4'($urandom), 4'h3};
        6:       rb = {3'($urandom), 1'b1, 2'($urandom), 2'b01};
        default: rb = 8'($urandom);
      endcase
      step($urandom_range(0, 4) != 0, rb, $urandom_range(0, 9) == 0,
           1'($urandom));
    end
    step(0, 8'h00, 0, 0);
    // R11: asynchronous reset clears a pending prefix
    step(1, 8'hFB, 0, 0);
    @(negedge clk); compare();
    rst_n = 1'b0; v = 0; pend = 0;
    {e_v, e_p, e_x, e_u, e_op, e_am} = '0; e_req = "R11";
    #1 compare();
    @(negedge clk); compare();
    rst_n = 1'b1;
    b = 8'h20; v = 1; ack = 0; predict();
    step(0, 8'h00, 0, 0);
    @(negedge clk); compare();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule